// File: doc/BRIEF.md
# ECP Forward-Channel Receiver with Run-Length Expansion

This block sits on the peripheral side of a parallel port running in extended-capability mode and receives the forward (host-to-peripheral) channel. The host places a byte and a command/data qualifier on the bus and raises a request. The block waits until the request has been stable for a programmable number of clock ticks, which sets the minimum strobe width and setup time. It then takes the byte. A data byte goes to a valid/ready output stream. A command byte either loads a 7-bit channel address or arms a run-length count for the next data byte. The acknowledge back to the host is held off until every output copy of the byte has been accepted downstream.

Only the host turns the bus around. Software asks for the reverse direction by setting a request bit, and that bit clears itself once the host switches to reverse. Every direction change sets a sticky status flag. The flag drives an interrupt output only while its enable input is high.

Top module: `ecp_fwd_rx`

## Requirements
- R1: After reset, hs_ack, out_valid, chan_addr_stb, rev_req, dirch_flag and dir_irq are all 0.
- R2: A byte taken with hs_is_data=1 and no armed run count appears on out_data exactly once.
- R3: A byte taken with hs_is_data=0 and bit 7 = 0 loads its bits 6:0 into chan_addr, pulses chan_addr_stb for one clock and produces no output byte.
- R4: A byte taken with hs_is_data=0 and bit 7 = 1 arms a count n from bits 6:0. The next data byte is then output n+1 times in a row, after which the count is cleared and later data bytes are output once.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data holds. hs_ack rises only after the last copy of a data byte has been accepted.
- R6: A byte is taken only after hs_req has been high for at least pw_ticks consecutive clocks, where a pw_ticks of 0 counts as 1. hs_ack then stays high until hs_req falls.
- R7: While host_dir_rev is 1, a raised hs_req is never taken: no hs_ack and no output byte.
- R8: A one-clock rev_req_set pulse sets rev_req. rev_req clears in the clock after host_dir_rev rises.
- R9: Any change of host_dir_rev sets dirch_flag, which stays set until a dirch_clr pulse clears it. dir_irq is high only while both dirch_flag and dirch_ie are high.
- R10: A run count of 0 outputs the next data byte once. An address command placed between a run command and its data byte leaves the armed count intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pw_ticks | input | TICK_W | Minimum request width in clock ticks |
| hs_req | input | 1 | Host strobe, byte valid on the bus |
| hs_is_data | input | 1 | 1 = data byte, 0 = command byte |
| hs_byte | input | 8 | Byte from the host |
| hs_ack | output | 1 | Acknowledge to the host |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the byte |
| chan_addr | output | 7 | Last decoded channel address |
| chan_addr_stb | output | 1 | One-clock strobe on a new address |
| host_dir_rev | input | 1 | Bus direction set by the host, 1 = reverse |
| rev_req_set | input | 1 | Software pulse that requests the reverse direction |
| rev_req | output | 1 | Pending reverse request |
| dirch_ie | input | 1 | Direction-change interrupt enable |
| dirch_clr | input | 1 | Clears the direction-change flag |
| dirch_flag | output | 1 | Sticky direction-change status |
| dir_irq | output | 1 | Direction-change interrupt |

## Verification
The stream is driven with plain data, with address commands, with run counts of 3, 2 and 0, and with a run count followed by an address and then data. These cases separate whether a count is applied, whether it is cleared afterwards, and whether an address wrongly disturbs it. A throttled out_ready shows whether stalled copies hold and whether the acknowledge waits for the last copy. The tick counts 0, 3 and 9 exercise the request-width floor. Toggling the direction with the enable on and then off separates the flag from the gated interrupt.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int RUN_W  = BYTE_W - 1;

  typedef enum logic [1:0] {CAP_IDLE, CAP_QUAL, CAP_BUSY, CAP_ACK} cap_state_t;

  // command byte: top bit selects run-length count versus channel address
  function automatic logic is_run_cmd(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  function automatic logic [RUN_W-1:0] cmd_field(input logic [BYTE_W-1:0] b);
    return b[RUN_W-1:0];
  endfunction
endpackage

// File: rtl/ecprx_capture.sv
module ecprx_capture
  import ecp_rx_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] pw_ticks,
  input  logic              hs_req,
  input  logic              hs_is_data,
  input  logic [BYTE_W-1:0] hs_byte,
  input  logic              dir_rev,
  input  logic              done,
  output logic              hs_ack,
  output logic              cap_pulse,
  output logic              cap_is_data,
  output logic [BYTE_W-1:0] cap_byte
);
  function automatic logic [TICK_W-1:0] width_floor(input logic [TICK_W-1:0] t);
    return (t == '0) ? TICK_W'(1) : t;
  endfunction

  cap_state_t        st;
  logic [TICK_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= CAP_IDLE;
      cnt         <= '0;
      cap_pulse   <= 1'b0;
      cap_is_data <= 1'b0;
      cap_byte    <= '0;
    end else begin
      cap_pulse <= 1'b0;
      unique case (st)
        CAP_IDLE: if (hs_req && !dir_rev) begin
          cnt <= TICK_W'(1);
          st  <= CAP_QUAL;
        end
        CAP_QUAL: begin
          if (!hs_req || dir_rev) begin
            st <= CAP_IDLE;
          end else if (cnt >= width_floor(pw_ticks)) begin
            cap_byte    <= hs_byte;
            cap_is_data <= hs_is_data;
            cap_pulse   <= 1'b1;
            st          <= CAP_BUSY;
          end else begin
            cnt <= cnt + TICK_W'(1);
          end
        end
        CAP_BUSY: if (done) st <= CAP_ACK;
        CAP_ACK:  if (!hs_req) st <= CAP_IDLE;
        default:  st <= CAP_IDLE;
      endcase
    end
  end

  assign hs_ack = (st == CAP_ACK);
endmodule

// File: rtl/ecprx_expand.sv
module ecprx_expand
  import ecp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_pulse,
  input  logic              cap_is_data,
  input  logic [BYTE_W-1:0] cap_byte,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic [RUN_W-1:0]  chan_addr,
  output logic              chan_addr_stb,
  output logic              done
);
  logic [RUN_W-1:0] run_cnt;
  logic [RUN_W-1:0] rep_left;
  logic             accept;
  logic             cmd_fire;

  assign accept   = out_valid && out_ready;
  assign cmd_fire = cap_pulse && !cap_is_data;
  assign done     = cmd_fire || (accept && rep_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt       <= '0;
      rep_left      <= '0;
      out_valid     <= 1'b0;
      out_data      <= '0;
      chan_addr     <= '0;
      chan_addr_stb <= 1'b0;
    end else begin
      chan_addr_stb <= 1'b0;
      if (cmd_fire) begin
        if (is_run_cmd(cap_byte)) begin
          run_cnt <= cmd_field(cap_byte);
        end else begin
          chan_addr     <= cmd_field(cap_byte);
          chan_addr_stb <= 1'b1;
        end
      end else if (cap_pulse) begin
        out_valid <= 1'b1;
        out_data  <= cap_byte;
        rep_left  <= run_cnt;
        run_cnt   <= '0;
      end else if (accept) begin
        if (rep_left == '0) out_valid <= 1'b0;
        else                rep_left  <= rep_left - RUN_W'(1);
      end
    end
  end
endmodule

// File: rtl/ecprx_dirctl.sv
module ecprx_dirctl (
  input  logic clk,
  input  logic rst_n,
  input  logic host_dir_rev,
  input  logic rev_req_set,
  input  logic dirch_ie,
  input  logic dirch_clr,
  output logic rev_req,
  output logic dirch_flag,
  output logic dir_irq,
  output logic dir_edge
);
  logic dir_q;
  logic dir_rise;

  assign dir_edge = host_dir_rev ^ dir_q;
  assign dir_rise = host_dir_rev & ~dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q      <= 1'b0;
      rev_req    <= 1'b0;
      dirch_flag <= 1'b0;
    end else begin
      dir_q <= host_dir_rev;
      if (dir_rise)         rev_req <= 1'b0;
      else if (rev_req_set) rev_req <= 1'b1;
      if (dir_edge)         dirch_flag <= 1'b1;
      else if (dirch_clr)   dirch_flag <= 1'b0;
    end
  end

  assign dir_irq = dirch_flag & dirch_ie;
endmodule

// File: rtl/ecp_fwd_rx.sv
module ecp_fwd_rx
  import ecp_rx_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] pw_ticks,
  input  logic              hs_req,
  input  logic              hs_is_data,
  input  logic [7:0]        hs_byte,
  output logic              hs_ack,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic [6:0]        chan_addr,
  output logic              chan_addr_stb,
  input  logic              host_dir_rev,
  input  logic              rev_req_set,
  output logic              rev_req,
  input  logic              dirch_ie,
  input  logic              dirch_clr,
  output logic              dirch_flag,
  output logic              dir_irq
);
  logic              cap_pulse_w;
  logic              cap_is_data_w;
  logic [BYTE_W-1:0] cap_byte_w;
  logic              cap_done_w;
  logic              dir_edge_w;

  ecprx_capture #(.TICK_W(TICK_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .pw_ticks(pw_ticks),
    .hs_req(hs_req), .hs_is_data(hs_is_data), .hs_byte(hs_byte),
    .dir_rev(host_dir_rev), .done(cap_done_w), .hs_ack(hs_ack),
    .cap_pulse(cap_pulse_w), .cap_is_data(cap_is_data_w), .cap_byte(cap_byte_w)
  );

  ecprx_expand u_exp (
    .clk(clk), .rst_n(rst_n), .cap_pulse(cap_pulse_w),
    .cap_is_data(cap_is_data_w), .cap_byte(cap_byte_w),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .chan_addr(chan_addr), .chan_addr_stb(chan_addr_stb), .done(cap_done_w)
  );

  ecprx_dirctl u_dir (
    .clk(clk), .rst_n(rst_n), .host_dir_rev(host_dir_rev),
    .rev_req_set(rev_req_set), .dirch_ie(dirch_ie), .dirch_clr(dirch_clr),
    .rev_req(rev_req), .dirch_flag(dirch_flag), .dir_irq(dir_irq),
    .dir_edge(dir_edge_w)
  );
endmodule

// File: rtl/ecp_fwd_rx_chk.sv
module ecp_fwd_rx_chk #(
  parameter int TICK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TICK_W-1:0] pw_ticks,
  input logic              hs_req,
  input logic              hs_ack,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              chan_addr_stb,
  input logic              host_dir_rev,
  input logic              rev_req,
  input logic              dirch_flag,
  input logic              dirch_ie,
  input logic              dir_irq,
  input logic              dir_edge
);
  logic [TICK_W-1:0] req_run;
  logic [TICK_W-1:0] min_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                req_run <= '0;
    else if (!hs_req)          req_run <= '0;
    else if (req_run != '1)    req_run <= req_run + TICK_W'(1);
  end

  assign min_run = (pw_ticks == '0) ? TICK_W'(1) : pw_ticks;

  p_addr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chan_addr_stb |=> !chan_addr_stb);

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_ack_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_ack) |-> !out_valid);

  p_ack_after_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_ack) |-> (req_run >= min_run));

  p_rev_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_dir_rev) |=> !rev_req);

  p_flag_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dir_edge |=> dirch_flag);

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dir_irq |-> dirch_ie);
endmodule

bind ecp_fwd_rx ecp_fwd_rx_chk #(.TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pw_ticks(pw_ticks), .hs_req(hs_req),
  .hs_ack(hs_ack), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .chan_addr_stb(chan_addr_stb),
  .host_dir_rev(host_dir_rev), .rev_req(rev_req), .dirch_flag(dirch_flag),
  .dirch_ie(dirch_ie), .dir_irq(dir_irq), .dir_edge(dir_edge_w)
);

// File: tb/ecp_fwd_rx_bench.sv
module ecp_fwd_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pw_ticks;
  logic       hs_req, hs_is_data;
  logic [7:0] hs_byte;
  logic       hs_ack;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready;
  logic [6:0] chan_addr;
  logic       chan_addr_stb;
  logic       host_dir_rev, rev_req_set, rev_req;
  logic       dirch_ie, dirch_clr, dirch_flag, dir_irq;

  ecp_fwd_rx u_ecp_fwd_rx (.*);

  always #10 clk = ~clk;

  int         n_tests = 0;
  int         n_fail = 0;
  logic [7:0] exp_q[$];
  int         got_cnt = 0;
  int         exp_total = 0;
  int         stb_cnt = 0;
  int         cyc = 0;
  bit         stall_mode = 0;
  bit         prev_hold = 0;
  logic [7:0] held;
  int         armed = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: sets ready, pops the scoreboard on every transfer
  always @(negedge clk) begin
    cyc++;
    if (prev_hold)
      chk(out_valid && out_data == held, "R5", "stalled byte held", out_data, held);
    out_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
    prev_hold = out_valid && !out_ready;
    held = out_data;
    if (chan_addr_stb) stb_cnt++;
    if (out_valid && out_ready) begin
      got_cnt++;
      if (exp_q.size() == 0) chk(0, "R4", "unexpected output byte", out_data, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R2", "output byte", out_data, e);
      end
    end
  end

  task automatic send(input bit is_data, input logic [7:0] b);
    int waited;
    int eff;
    if (is_data) begin
      for (int i = 0; i <= armed; i++) exp_q.push_back(b);
      exp_total += armed + 1;
      armed = 0;
    end else if (b[7]) armed = int'(b[6:0]);
    eff = (pw_ticks == 0) ? 1 : int'(pw_ticks);
    @(negedge clk);
    hs_byte = b; hs_is_data = is_data; hs_req = 1'b1;
    waited = 0;
    while (!hs_ack && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk(waited >= eff, "R6", "ack delay vs pw_ticks", waited, eff);
    chk(exp_q.size() == 0, "R5", "copies left when ack rose", exp_q.size(), 0);
    hs_req = 1'b0;
    waited = 0;
    while (hs_ack && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk(!hs_ack, "R6", "ack released after req low", hs_ack, 0);
  endtask

  task automatic send_addr(input logic [7:0] b);
    int s0, g0;
    s0 = stb_cnt; g0 = got_cnt;
    send(0, b);
    chk(chan_addr == b[6:0], "R3", "chan_addr", chan_addr, b[6:0]);
    chk(stb_cnt == s0 + 1, "R3", "addr strobe count", stb_cnt, s0 + 1);
    chk(got_cnt == g0, "R3", "no output byte", got_cnt, g0);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; pw_ticks = 8'd3; hs_req = 0; hs_is_data = 0; hs_byte = 0;
    out_ready = 1; host_dir_rev = 0; rev_req_set = 0; dirch_ie = 0; dirch_clr = 0;
    repeat (3) @(negedge clk);
    chk(!hs_ack && !out_valid && !chan_addr_stb, "R1", "handshake/stream idle",
        {hs_ack, out_valid, chan_addr_stb}, 0);
    chk(!rev_req && !dirch_flag && !dir_irq, "R1", "direction state idle",
        {rev_req, dirch_flag, dir_irq}, 0);
    rst_n = 1;
    @(negedge clk);

    send(1, 8'h5A);                                    // R2 single byte
    send_addr(8'h12);                                  // R3
    send(0, 8'h83); send(1, 8'hC3); send(1, 8'h11);    // R4 run 3 then cleared
    send(0, 8'h80); send(1, 8'h22);                    // R10 count zero
    send(0, 8'h82); send_addr(8'h05); send(1, 8'h33);  // R10 address keeps count
    stall_mode = 1;                                    // R5 throttled ready
    send(0, 8'h84); send(1, 8'hA5); send(1, 8'h01);
    stall_mode = 0;
    pw_ticks = 8'd0; send(1, 8'h77);                   // R6 floor of one tick
    pw_ticks = 8'd9; send(1, 8'h78);                   // R6 longer width

    // R8 request bit set by software
    dirch_ie = 1;
    @(negedge clk); rev_req_set = 1;
    @(negedge clk); rev_req_set = 0;
    chk(rev_req, "R8", "rev_req after set pulse", rev_req, 1);
    host_dir_rev = 1;
    @(negedge clk);
    chk(!rev_req, "R8", "rev_req cleared on turnaround", rev_req, 0);
    chk(dirch_flag && dir_irq, "R9", "flag and irq on reverse", {dirch_flag, dir_irq}, 3);
    // R7 no capture while reversed
    begin
      int g0;
      bit acked;
      g0 = got_cnt; acked = 0;
      hs_byte = 8'h99; hs_is_data = 1; hs_req = 1;
      repeat (30) begin @(negedge clk); if (hs_ack) acked = 1; end
      hs_req = 0;
      chk(!acked, "R7", "no ack while reversed", acked, 0);
      chk(got_cnt == g0, "R7", "no output while reversed", got_cnt, g0);
    end
    @(negedge clk); dirch_clr = 1;
    @(negedge clk); dirch_clr = 0;
    chk(!dirch_flag && !dir_irq, "R9", "flag cleared", {dirch_flag, dir_irq}, 0);
    dirch_ie = 0; host_dir_rev = 0;
    @(negedge clk);
    chk(dirch_flag && !dir_irq, "R9", "flag set, irq masked", {dirch_flag, dir_irq}, 2);
    dirch_clr = 1; @(negedge clk); dirch_clr = 0;

    send(1, 8'hEE);                                    // R4 count stays cleared
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    chk(got_cnt == exp_total, "R4", "total output bytes", got_cnt, exp_total);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule